// File: doc/BRIEF.md
# PIPE Receive 128-bit Block Assembler

This block sits on the link-layer side of a PIPE-style receive path, one lane per instance, clocked by the parallel interface clock. Each cycle it may be offered a 64-bit data word, a valid flag, a 2-bit start code and a 2-bit sync header. At the two highest rate settings it gathers the incoming bytes into complete 128-bit blocks. Each finished block is presented for one cycle together with the sync header that arrived with its start. An error pulse marks an illegal start code or a start that cuts a block short.

The rate input sets how much of the bus is used. At the middle rate a beat carries 32 bits (bits 31:0), so a block takes four valid beats. At the top rate a beat carries all 64 bits, so a block takes two beats. A block may also begin in the upper half of a beat, and it then ends in the lower half of a later one. At the two lowest rates there is no block framing and the assembler does nothing. Beats whose valid flag is low are skipped. They do not break the block in progress.

Top module: `rxblk_assembler`

## Requirements
- R1: While `rst_n` is low, `blk_valid`, `blk_err`, `blk_hdr` and `blk_data` are all zero. Any partial block is discarded, and after release the block waits for a start code.
- R2: When `rate` is 2'b00 or 2'b01, no beat causes `blk_valid` or `blk_err`. Any partial block is dropped.
- R3: A beat with `rx_valid` low is ignored entirely: its data, its start code and its header have no effect.
- R4: When `rate` is 2'b10, start code 2'b01 begins a block with `rx_data[31:0]` as its first word. Each later valid beat with code 2'b00 adds `rx_data[31:0]`, and bits 63:32 are ignored. `blk_valid` pulses in the cycle after the fourth word.
- R5: When `rate` is 2'b10, start code 2'b10 does not start a block and is treated as continuation data.
- R6: When `rate` is 2'b10 or 2'b11, start code 2'b11 on a valid beat pulses `blk_err`. It discards any partial block, and the assembler then waits for a start.
- R7: When `rate` is 2'b11, start code 2'b01 takes all 64 bits as words 0 and 1. The next valid continuation beat supplies words 2 and 3 and completes the block.
- R8: When `rate` is 2'b11, start code 2'b10 begins a block with `rx_data[63:32]` as word 0. Words are then appended in bus order, lower half first. The block completes at the lower half that supplies word 3, and the upper half of that beat either starts the next block (code 2'b10) or is dropped (code 2'b00).
- R9: `blk_hdr` is the `rx_hdr` value sampled on the beat that started the block. Header values on all other beats are ignored.
- R10: A start code of 2'b01 or 2'b10 that arrives before the current block is complete pulses `blk_err`. The partial block is discarded, and a new block begins from that beat.
- R11: Bytes are packed little-endian: word k of a block sits at `blk_data[32k+31:32k]`, so the first received byte is at bits 7:0.
- R12: Continuation beats that arrive while no block is in progress are dropped.
- R13: `blk_valid` and `blk_err` are one-cycle pulses, registered one cycle after the beat that causes them, and they never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate | input | 2 | 00/01 low rates (no framing), 10 middle rate (32-bit), 11 top rate (64-bit) |
| rx_data | input | 64 | Receive data beat |
| rx_valid | input | 1 | High when the beat is to be used |
| rx_start | input | 2 | Start code: 00 none, 01 lower half, 10 upper half, 11 illegal |
| rx_hdr | input | 2 | Sync header, sampled on start beats |
| blk_valid | output | 1 | One-cycle strobe for a completed block |
| blk_data | output | 128 | Completed block, little-endian |
| blk_hdr | output | 2 | Sync header of the completed block |
| blk_err | output | 1 | One-cycle error pulse |

## Verification
At the top rate, a single beat with start code 10 can both finish the block in progress (through its lower half) and open a new one (through its upper half). The bench starts a block in the upper half, adds one full continuation beat, and then sends a second upper-half start. It checks that the old block appears with its own header and no error. It then checks that the following two beats complete the new block with the new header. A contrasting case sends an upper-half start while only one word is held, and that case must raise the error instead.

// File: rtl/rxblk_pkg.sv
package rxblk_pkg;

  typedef enum logic [1:0] {
    RATE_LO1 = 2'b00,
    RATE_LO2 = 2'b01,
    RATE_MID = 2'b10,
    RATE_TOP = 2'b11
  } rate_e;

  typedef enum logic [1:0] {
    SK_NONE  = 2'b00,
    SK_LOWER = 2'b01,
    SK_UPPER = 2'b10,
    SK_BAD   = 2'b11
  } start_kind_e;

endpackage

// File: rtl/rxblk_start_decode.sv
module rxblk_start_decode
  import rxblk_pkg::*;
(
  input  logic [1:0]  code,
  input  logic        wide,
  output start_kind_e kind
);

  always_comb begin
    unique case (code)
      2'b00:   kind = SK_NONE;
      2'b01:   kind = SK_LOWER;
      2'b10:   kind = wide ? SK_UPPER : SK_NONE;
      default: kind = SK_BAD;
    endcase
  end

endmodule

// File: rtl/rxblk_word_pack.sv
module rxblk_word_pack #(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  localparam int CNT_W    = $clog2(BLK_WORDS + 1),
  localparam int BLK_W    = WORD_W * BLK_WORDS
) (
  input  logic [BLK_W-1:0]  base,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  input  logic [1:0]        nwr,
  output logic [BLK_W-1:0]  packed_blk,
  output logic              full
);

  logic [CNT_W:0] sum;
  logic [CNT_W:0] nxt_slot;

  assign sum      = {1'b0, cnt} + (CNT_W+1)'(nwr);
  assign nxt_slot = {1'b0, cnt} + (CNT_W+1)'(1);
  assign full     = (nwr != 2'd0) && (sum >= (CNT_W+1)'(BLK_WORDS));

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_slot
    logic sel0, sel1;
    assign sel0 = (nwr != 2'd0) && (cnt == CNT_W'(i));
    assign sel1 = (nwr == 2'd2) && (nxt_slot == (CNT_W+1)'(i));
    assign packed_blk[i*WORD_W +: WORD_W] = sel0 ? w0 :
                                            sel1 ? w1 :
                                            base[i*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/rxblk_assembler.sv
module rxblk_assembler
  import rxblk_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 4,
  localparam int BUS_W    = 2 * WORD_W,
  localparam int BLK_W    = WORD_W * BLK_WORDS,
  localparam int CNT_W    = $clog2(BLK_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate,
  input  logic [BUS_W-1:0] rx_data,
  input  logic             rx_valid,
  input  logic [1:0]       rx_start,
  input  logic [1:0]       rx_hdr,
  output logic             blk_valid,
  output logic [BLK_W-1:0] blk_data,
  output logic [1:0]       blk_hdr,
  output logic             blk_err
);

  logic             framing, wide;
  logic [WORD_W-1:0] lo_w, hi_w;
  start_kind_e      kind;

  assign framing = rate[1];
  assign wide    = (rate == RATE_TOP);
  assign lo_w    = rx_data[WORD_W-1:0];
  assign hi_w    = rx_data[BUS_W-1:WORD_W];

  rxblk_start_decode u_dec (
    .code (rx_start),
    .wide (wide),
    .kind (kind)
  );

  // block state
  logic             act_q, act_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [BLK_W-1:0] buf_q, buf_n;
  logic [1:0]       hdr_q, hdr_n;
  logic             st_en;
  // output stage
  logic             vld_n, err_n;
  logic [BLK_W-1:0] odata_n;
  logic [1:0]       ohdr_n;

  logic [1:0]       nwr;
  logic [BLK_W-1:0] packed_blk;
  logic             full;

  always_comb begin
    nwr = 2'd0;
    if (act_q) begin
      if (kind == SK_NONE)       nwr = wide ? 2'd2 : 2'd1;
      else if (kind == SK_UPPER) nwr = 2'd1;
    end
  end

  rxblk_word_pack #(
    .WORD_W    (WORD_W),
    .BLK_WORDS (BLK_WORDS)
  ) u_pack (
    .base       (buf_q),
    .cnt        (cnt_q),
    .w0         (lo_w),
    .w1         (hi_w),
    .nwr        (nwr),
    .packed_blk (packed_blk),
    .full       (full)
  );

  // next-state process
  always_comb begin
    act_n   = act_q;
    cnt_n   = cnt_q;
    buf_n   = buf_q;
    hdr_n   = hdr_q;
    vld_n   = 1'b0;
    err_n   = 1'b0;
    odata_n = packed_blk;
    ohdr_n  = hdr_q;
    if (!framing) begin
      act_n = 1'b0;
      cnt_n = '0;
    end else if (rx_valid) begin
      unique case (kind)
        SK_NONE: begin
          if (act_q) begin
            if (full) begin
              vld_n = 1'b1;
              act_n = 1'b0;
              cnt_n = '0;
            end else begin
              buf_n = packed_blk;
              cnt_n = cnt_q + CNT_W'(nwr);
            end
          end
        end
        SK_BAD: begin
          err_n = 1'b1;
          act_n = 1'b0;
          cnt_n = '0;
        end
        default: begin
          if (act_q) begin
            if (kind == SK_UPPER && full) vld_n = 1'b1;
            else                          err_n = 1'b1;
          end
          act_n = 1'b1;
          hdr_n = rx_hdr;
          buf_n = '0;
          if (kind == SK_UPPER) begin
            buf_n[WORD_W-1:0] = hi_w;
            cnt_n             = CNT_W'(1);
          end else if (wide) begin
            buf_n[BUS_W-1:0] = rx_data;
            cnt_n            = CNT_W'(2);
          end else begin
            buf_n[WORD_W-1:0] = lo_w;
            cnt_n             = CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign st_en = !framing || rx_valid;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      cnt_q     <= '0;
      buf_q     <= '0;
      hdr_q     <= '0;
      blk_valid <= 1'b0;
      blk_err   <= 1'b0;
      blk_data  <= '0;
      blk_hdr   <= '0;
    end else begin
      blk_valid <= vld_n;
      blk_err   <= err_n;
      if (st_en) begin
        act_q <= act_n;
        cnt_q <= cnt_n;
        buf_q <= buf_n;
        hdr_q <= hdr_n;
      end
      if (vld_n) begin
        blk_data <= odata_n;
        blk_hdr  <= ohdr_n;
      end
    end
  end

  // assertions
  assert_slow_rate_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rate[1]) |-> (!blk_valid && !blk_err));

  assert_gap_no_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid || blk_err) |-> $past(rx_valid));

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(BLK_WORDS));

  assert_idle_cnt_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (cnt_q == '0));

  assert_strobe_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |=> !blk_valid);

  assert_no_strobe_with_err_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_valid && blk_err));

endmodule

// File: tb/rxblk_assembler_bench.sv
module rxblk_assembler_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   rate;
  logic [63:0]  rx_data;
  logic         rx_valid;
  logic [1:0]   rx_start;
  logic [1:0]   rx_hdr;
  logic         blk_valid;
  logic [127:0] blk_data;
  logic [1:0]   blk_hdr;
  logic         blk_err;

  int nvec = 0;
  int nbad = 0;

  always #2.5 clk = ~clk;

  rxblk_assembler u_rxblk_assembler (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate      (rate),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_start  (rx_start),
    .rx_hdr    (rx_hdr),
    .blk_valid (blk_valid),
    .blk_data  (blk_data),
    .blk_hdr   (blk_hdr),
    .blk_err   (blk_err)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic v, input logic [1:0] st, input logic [1:0] hd,
                      input logic [63:0] d);
    @(negedge clk);
    rx_valid = v; rx_start = st; rx_hdr = hd; rx_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet(input string tag);
    chk({tag, " strobe"}, 128'(blk_valid), 128'd0);
    chk({tag, " err"},    128'(blk_err),   128'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rate = 2'b10; rx_valid = 1'b0; rx_start = 2'b00;
    rx_hdr = 2'b00; rx_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset strobe", 128'(blk_valid), 128'd0);
    chk("R1 reset err",    128'(blk_err),   128'd0);
    chk("R1 reset data",   blk_data,        128'd0);
    chk("R1 reset hdr",    128'(blk_hdr),   128'd0);
    @(negedge clk); rst_n = 1'b1;
    // partial block lost across a reset
    beat(1'b1, 2'b01, 2'b01, 64'h0000_0000_1111_1111);
    beat(1'b1, 2'b00, 2'b01, 64'h0000_0000_2222_2222);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    beat(1'b1, 2'b00, 2'b01, 64'h0000_0000_3333_3333);
    quiet("R1 after reset");
    beat(1'b1, 2'b00, 2'b01, 64'h0000_0000_4444_4444);
    quiet("R1 after reset");
  endtask

  task automatic t_mid_basic;
    rate = 2'b10;
    beat(1'b1, 2'b01, 2'b10, 64'hDEAD_BEEF_0302_0100);
    quiet("R4 beat0");
    beat(1'b1, 2'b00, 2'b00, 64'hFFFF_FFFF_0706_0504);
    quiet("R4 beat1");
    beat(1'b1, 2'b00, 2'b11, 64'h1234_5678_0B0A_0908);
    quiet("R4 beat2");
    beat(1'b1, 2'b00, 2'b00, 64'hCAFE_F00D_0F0E_0D0C);
    chk("R4 strobe", 128'(blk_valid), 128'd1);
    chk("R4 data",   blk_data, 128'h0F0E0D0C_0B0A0908_07060504_03020100);
    chk("R9 hdr",    128'(blk_hdr), 128'd2);
    chk("R11 first byte", 128'(blk_data[7:0]), 128'h00);
    chk("R11 second byte", 128'(blk_data[15:8]), 128'h01);
    chk("R13 err with strobe", 128'(blk_err), 128'd0);
    beat(1'b0, 2'b00, 2'b00, 64'd0);
    chk("R13 strobe one cycle", 128'(blk_valid), 128'd0);
  endtask

  task automatic t_mid_gaps;
    rate = 2'b10;
    beat(1'b1, 2'b01, 2'b01, 64'h0000_0000_E000_0000);
    beat(1'b0, 2'b01, 2'b11, 64'h0000_0000_BAD0_BAD0);
    quiet("R3 gap start ignored");
    beat(1'b1, 2'b10, 2'b10, 64'h0000_0000_E111_1111);
    quiet("R5 code10 continuation");
    beat(1'b0, 2'b11, 2'b00, 64'h0000_0000_BAD1_BAD1);
    quiet("R3 gap illegal ignored");
    beat(1'b1, 2'b00, 2'b00, 64'h0000_0000_E222_2222);
    beat(1'b1, 2'b00, 2'b11, 64'h0000_0000_E333_3333);
    chk("R3 strobe after gaps", 128'(blk_valid), 128'd1);
    chk("R5 data", blk_data, 128'hE3333333_E2222222_E1111111_E0000000);
    chk("R9 hdr from start beat", 128'(blk_hdr), 128'd1);
  endtask

  task automatic t_illegal;
    rate = 2'b10;
    beat(1'b1, 2'b01, 2'b01, 64'h0000_0000_F000_0000);
    beat(1'b1, 2'b00, 2'b01, 64'h0000_0000_F111_1111);
    beat(1'b1, 2'b11, 2'b01, 64'h0000_0000_F222_2222);
    chk("R6 illegal err", 128'(blk_err), 128'd1);
    chk("R6 illegal strobe", 128'(blk_valid), 128'd0);
    for (int i = 0; i < 4; i++) begin
      beat(1'b1, 2'b00, 2'b00, 64'h0000_0000_A5A5_0000 + 64'(i));
      quiet("R12 dropped continuation");
    end
    rate = 2'b11;
    beat(1'b1, 2'b01, 2'b01, 64'h0101_0101_0202_0202);
    beat(1'b1, 2'b11, 2'b01, 64'h0303_0303_0404_0404);
    chk("R6 illegal err top rate", 128'(blk_err), 128'd1);
    beat(1'b1, 2'b00, 2'b01, 64'h0505_0505_0606_0606);
    quiet("R6 discarded top rate");
  endtask

  task automatic t_premature;
    rate = 2'b10;
    beat(1'b1, 2'b01, 2'b00, 64'h0000_0000_6000_0000);
    beat(1'b1, 2'b00, 2'b00, 64'h0000_0000_6111_1111);
    beat(1'b1, 2'b01, 2'b11, 64'h0000_0000_7000_0000);
    chk("R10 early start err", 128'(blk_err), 128'd1);
    chk("R10 early start strobe", 128'(blk_valid), 128'd0);
    beat(1'b1, 2'b00, 2'b00, 64'h0000_0000_7111_1111);
    chk("R13 err one cycle", 128'(blk_err), 128'd0);
    beat(1'b1, 2'b00, 2'b00, 64'h0000_0000_7222_2222);
    quiet("R10 restart beat2");
    beat(1'b1, 2'b00, 2'b00, 64'h0000_0000_7333_3333);
    chk("R10 restart strobe", 128'(blk_valid), 128'd1);
    chk("R10 restart data", blk_data, 128'h73333333_72222222_71111111_70000000);
    chk("R10 restart hdr", 128'(blk_hdr), 128'd3);
  endtask

  task automatic t_top_lower;
    rate = 2'b11;
    beat(1'b1, 2'b01, 2'b10, 64'hB111_1111_B000_0000);
    quiet("R7 first beat");
    beat(1'b1, 2'b00, 2'b01, 64'hB333_3333_B222_2222);
    chk("R7 strobe", 128'(blk_valid), 128'd1);
    chk("R7 data", blk_data, 128'hB3333333_B2222222_B1111111_B0000000);
    chk("R7 hdr", 128'(blk_hdr), 128'd2);
  endtask

  task automatic t_top_upper;
    rate = 2'b11;
    beat(1'b1, 2'b10, 2'b01, 64'hC000_0000_DEAD_DEAD);
    quiet("R8 upper start");
    beat(1'b1, 2'b00, 2'b00, 64'hC222_2222_C111_1111);
    quiet("R8 middle");
    beat(1'b1, 2'b10, 2'b10, 64'hD000_0000_C333_3333);
    chk("R8 span strobe", 128'(blk_valid), 128'd1);
    chk("R8 span err", 128'(blk_err), 128'd0);
    chk("R8 span data", blk_data, 128'hC3333333_C2222222_C1111111_C0000000);
    chk("R9 span hdr", 128'(blk_hdr), 128'd1);
    beat(1'b1, 2'b00, 2'b00, 64'hD222_2222_D111_1111);
    quiet("R8 second block middle");
    beat(1'b1, 2'b00, 2'b01, 64'hBEEF_BEEF_D333_3333);
    chk("R8 tail strobe", 128'(blk_valid), 128'd1);
    chk("R8 tail data", blk_data, 128'hD3333333_D2222222_D1111111_D0000000);
    chk("R9 tail hdr", 128'(blk_hdr), 128'd2);
    beat(1'b1, 2'b00, 2'b00, 64'h1111_1111_2222_2222);
    quiet("R8 excess upper dropped");
    beat(1'b1, 2'b10, 2'b00, 64'hE000_0000_0000_0000);
    beat(1'b1, 2'b10, 2'b00, 64'hF000_0000_E111_1111);
    chk("R10 early upper start err", 128'(blk_err), 128'd1);
    chk("R10 early upper start strobe", 128'(blk_valid), 128'd0);
    beat(1'b1, 2'b11, 2'b00, 64'd0);
  endtask

  task automatic t_slow_rates;
    rate = 2'b00;
    beat(1'b1, 2'b01, 2'b01, 64'h1);
    quiet("R2 low rate start");
    for (int i = 0; i < 3; i++) begin
      beat(1'b1, 2'b00, 2'b01, 64'h10 + 64'(i));
      quiet("R2 low rate data");
    end
    beat(1'b1, 2'b11, 2'b01, 64'h2);
    quiet("R2 low rate illegal");
    rate = 2'b01;
    beat(1'b1, 2'b01, 2'b01, 64'h3);
    beat(1'b1, 2'b11, 2'b01, 64'h4);
    quiet("R2 second low rate");
    rate = 2'b10;
    for (int i = 0; i < 4; i++) begin
      beat(1'b1, 2'b00, 2'b00, 64'h20 + 64'(i));
      quiet("R2 no block kept");
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_mid_basic();
    t_mid_gaps();
    t_illegal();
    t_premature();
    t_top_lower();
    t_top_upper();
    t_slow_rates();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule